// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the purely combinational execute stage of a small 32-bit load-store processor. Each evaluation takes two register operands, a 16-bit immediate, a 5-bit shift count and a 5-bit operation code. It returns a 32-bit result together with a flag that is high when that result is zero. The flag serves the equal and not-equal branch tests. Multiply, divide and overflow traps are not part of this block.

The block has no state and no state machine: a new operation can be presented every cycle. An extension unit widens the immediate according to the operation. Arithmetic and compare operations sign-extend it, logic operations zero-extend it, and the upper-immediate operation moves it into the high half. A barrel shifter built from one stage per bit of the shift count handles the three shift kinds. The count comes from the instruction field or, for the variable forms, from the first operand. A comparator produces the signed and unsigned less-than results side by side.

Top module: `int_exec_alu`

## Requirements
- R1: Codes 13 (add-immediate), 14 (signed less-than-immediate) and 15 (unsigned less-than-immediate) use the immediate sign-extended, with imm bit 15 copied into bits 31:16, as the second operand. Code 13 gives src_a + ext.
- R2: Codes 16 (and-immediate) and 17 (or-immediate) use the immediate zero-extended, with bits 31:16 equal to 0, and give src_a & ext and src_a | ext.
- R3: Code 18 (upper-immediate) gives imm in bits 31:16 and zeros in bits 15:0, whatever src_a and src_b hold.
- R4: Codes 5 (register) and 14 (immediate) give 1 when src_a is below the second operand as two's complement numbers, and 0 otherwise. Bits 31:1 are always 0.
- R5: Codes 6 (register) and 15 (immediate) give 1 when src_a is below the second operand as unsigned magnitudes, and 0 otherwise. With src_a = 0xFFFFFFFF and src_b = 0, code 5 gives 1 and code 6 gives 0.
- R6: Code 7 shifts src_b left and code 8 shifts it right logically by shamt (0 to 31). Vacated positions fill with zeros.
- R7: Code 9 shifts src_b right arithmetically by shamt, filling vacated positions with a copy of src_b bit 31.
- R8: Codes 10, 11 and 12 perform the left, logical-right and arithmetic-right shifts of src_b. Their amount is src_a bits 4:0, and the shamt input has no effect.
- R9: Code 0 gives src_a + src_b and code 1 gives src_a - src_b, both modulo 2^32.
- R10: Code 2 gives src_a & src_b, code 3 gives src_a | src_b, and code 4 gives the bitwise inverse of (src_a | src_b).
- R11: zero is 1 exactly when all 32 result bits are 0, for every code.
- R12: Codes 19 to 31 are undefined: result is 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation select, encodings as in the requirements |
| src_a | input | 32 | First register operand; bits 4:0 are the variable shift amount |
| src_b | input | 32 | Second register operand; the data for all shifts |
| imm16 | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift count field for the fixed shifts |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result equals zero |

## Verification
Every code is crossed with a grid of boundary operands: 0, 1, the largest and smallest signed values, all ones, and mixed patterns. This grid separates signed from unsigned ordering and exposes sign-versus-zero extension of immediates with bit 15 set. Each shift kind is swept over all 32 counts, with a negative and a positive data word. The sweep tells fill direction and fill value apart. For the variable forms, src_a carries the count while its upper bits and the shamt field carry unrelated values, so using the wrong count source changes the result. A long pseudo-random run over all 32 codes, including the undefined ones, then checks the result and the zero flag against an arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        ALU_ADD   = 5'd0,
        ALU_SUB   = 5'd1,
        ALU_AND   = 5'd2,
        ALU_OR    = 5'd3,
        ALU_NOR   = 5'd4,
        ALU_SLT   = 5'd5,
        ALU_SLTU  = 5'd6,
        ALU_SLL   = 5'd7,
        ALU_SRL   = 5'd8,
        ALU_SRA   = 5'd9,
        ALU_SLLV  = 5'd10,
        ALU_SRLV  = 5'd11,
        ALU_SRAV  = 5'd12,
        ALU_ADDI  = 5'd13,
        ALU_SLTI  = 5'd14,
        ALU_SLTIU = 5'd15,
        ALU_ANDI  = 5'd16,
        ALU_ORI   = 5'd17,
        ALU_LUI   = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'd0,
        SH_RLOG = 2'd1,
        SH_RARI = 2'd2
    } shift_mode_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HIGH = 2'd2
    } ext_mode_e;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  ext_mode_e       mode,
    input  logic [IW-1:0]   imm,
    output logic [W-1:0]    ext
);

    localparam int HW = W - IW;

    always_comb begin
        unique case (mode)
            EXT_SIGN: ext = {{HW{imm[IW-1]}}, imm};
            EXT_ZERO: ext = {{HW{1'b0}}, imm};
            EXT_HIGH: ext = {imm, {HW{1'b0}}};
            default:  ext = '0;
        endcase
    end

    always_comb begin
        if (mode == EXT_SIGN || mode == EXT_ZERO)
            AST_EXT_LOW_KEPT: assert (ext[IW-1:0] == imm); // R1
        if (mode == EXT_HIGH)
            AST_EXT_HIGH_LOW_CLEAR: assert (ext[IW-1:0] == '0); // R3
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    assign lt_signed   = $signed(lhs) < $signed(rhs);
    assign lt_unsigned = lhs < rhs;

    always_comb begin
        if (lhs[W-1] == rhs[W-1])
            AST_CMP_SAME_SIGN_AGREE: assert (lt_signed == lt_unsigned); // R5
        if (lhs[W-1] != rhs[W-1])
            AST_CMP_MIXED_SIGN_DIFFER: assert (lt_signed != lt_unsigned); // R4
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [SW-1:0] amount,
    input  shift_mode_e   mode,
    output logic [W-1:0]  q
);

    logic [SW:0][W-1:0] stage;
    logic               fill;

    assign fill     = (mode == SH_RARI) ? data[W-1] : 1'b0;
    assign stage[0] = data;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = !amount[i]        ? stage[i] :
                            (mode == SH_LEFT) ? {stage[i][W-1-STEP:0], {STEP{1'b0}}} :
                                                {{STEP{fill}}, stage[i][W-1:STEP]};
    end

    assign q = stage[SW];

    always_comb begin
        if (amount == '0)
            AST_SHIFT_NONE_PASS: assert (q == data); // R6
        if (mode == SH_RARI)
            AST_SHIFT_SIGN_KEPT: assert (q[W-1] == data[W-1]); // R7
        if (mode == SH_LEFT && amount != '0)
            AST_SHIFT_LEFT_LSB_CLEAR: assert (q[0] == 1'b0); // R6
    end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16,
    localparam int SW = $clog2(W)
) (
    input  logic [4:0]    op_code,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [IW-1:0] imm16,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  result,
    output logic          zero
);

    ext_mode_e     ext_mode;
    shift_mode_e   sh_mode;
    logic          use_imm;
    logic          sh_var;
    logic [W-1:0]  imm_x;
    logic [W-1:0]  opnd_b;
    logic [SW-1:0] sh_amt;
    logic [W-1:0]  sh_q;
    logic          lt_s;
    logic          lt_u;

    // operation decode
    always_comb begin
        ext_mode = EXT_SIGN;
        sh_mode  = SH_LEFT;
        use_imm  = 1'b0;
        sh_var   = 1'b0;
        unique case (op_code)
            ALU_SRL:   sh_mode = SH_RLOG;
            ALU_SRA:   sh_mode = SH_RARI;
            ALU_SLLV:  sh_var  = 1'b1;
            ALU_SRLV:  begin sh_var = 1'b1; sh_mode = SH_RLOG; end
            ALU_SRAV:  begin sh_var = 1'b1; sh_mode = SH_RARI; end
            ALU_ADDI,
            ALU_SLTI,
            ALU_SLTIU: use_imm = 1'b1;
            ALU_ANDI,
            ALU_ORI:   begin use_imm = 1'b1; ext_mode = EXT_ZERO; end
            ALU_LUI:   ext_mode = EXT_HIGH;
            default:   ;
        endcase
    end

    alu_imm_ext #(.W(W), .IW(IW)) u_ext (
        .mode (ext_mode),
        .imm  (imm16),
        .ext  (imm_x)
    );

    assign opnd_b = use_imm ? imm_x : src_b;
    assign sh_amt = sh_var ? src_a[SW-1:0] : shamt;

    alu_compare #(.W(W)) u_cmp (
        .lhs         (src_a),
        .rhs         (opnd_b),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_shifter #(.W(W)) u_shift (
        .data   (src_b),
        .amount (sh_amt),
        .mode   (sh_mode),
        .q      (sh_q)
    );

    // result select
    always_comb begin
        unique case (op_code)
            ALU_ADD, ALU_ADDI:   result = src_a + opnd_b;
            ALU_SUB:             result = src_a - opnd_b;
            ALU_AND, ALU_ANDI:   result = src_a & opnd_b;
            ALU_OR,  ALU_ORI:    result = src_a | opnd_b;
            ALU_NOR:             result = ~(src_a | opnd_b);
            ALU_SLT, ALU_SLTI:   result = {{(W-1){1'b0}}, lt_s};
            ALU_SLTU, ALU_SLTIU: result = {{(W-1){1'b0}}, lt_u};
            ALU_SLL, ALU_SRL, ALU_SRA,
            ALU_SLLV, ALU_SRLV, ALU_SRAV: result = sh_q;
            ALU_LUI:             result = imm_x;
            default:             result = '0;
        endcase
    end

    assign zero = (result == '0);

    always_comb begin
        if (op_code == ALU_SLT || op_code == ALU_SLTU ||
            op_code == ALU_SLTI || op_code == ALU_SLTIU)
            AST_CMP_ONE_BIT: assert (result[W-1:1] == '0); // R4
        if (op_code == ALU_LUI)
            AST_UPPER_IMM_PLACED: assert (result == {imm16, {(W-IW){1'b0}}}); // R3
        if (op_code == ALU_NOR)
            AST_NOR_DISJOINT: assert ((result & (src_a | src_b)) == '0); // R10
        if (op_code == ALU_ANDI)
            AST_ANDI_HIGH_CLEAR: assert (result[W-1:IW] == '0); // R2
        if (op_code > ALU_LUI)
            AST_UNDEF_QUIET: assert (zero); // R12
    end

endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        zero;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    int_exec_alu u_int_exec_alu (
        .op_code (op_code),
        .src_a   (src_a),
        .src_b   (src_b),
        .imm16   (imm16),
        .shamt   (shamt),
        .result  (result),
        .zero    (zero)
    );

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_8765;
            6: return 32'hF0F0_7F3C;
            default: return 32'h0000_8001;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1:         return "R9";
            2, 3, 4:      return "R10";
            5, 14:        return "R4";
            6, 15:        return "R5";
            7, 8:         return "R6";
            9:            return "R7";
            10, 11, 12:   return "R8";
            13:           return "R1";
            16, 17:       return "R2";
            18:           return "R3";
            default:      return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model(input int op, input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] se;
        logic [31:0] ze;
        se = {{16{im[15]}}, im};
        ze = {16'h0000, im};
        case (op)
            0:  return a + b;
            1:  return a - b;
            2:  return a & b;
            3:  return a | b;
            4:  return ~(a | b);
            5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6:  return (a < b) ? 32'd1 : 32'd0;
            7:  return b << sh;
            8:  return b >> sh;
            9:  return $signed(b) >>> sh;
            10: return b << a[4:0];
            11: return b >> a[4:0];
            12: return $signed(b) >>> a[4:0];
            13: return a + se;
            14: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            15: return (a < se) ? 32'd1 : 32'd0;
            16: return a & ze;
            17: return a | ze;
            18: return {im, 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] exp_r;
        @(posedge clk);
        op_code = op[4:0];
        src_a   = a;
        src_b   = b;
        imm16   = im;
        shamt   = sh;
        @(negedge clk);
        exp_r = model(op, a, b, im, sh);
        n_vec++;
        if (result !== exp_r) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: result %h expected %h",
                     tag_of(op), op, a, b, im, sh, result, exp_r);
        end
        if (zero !== (exp_r == 32'h0)) begin
            n_bad++;
            $display("FAIL R11 op=%0d: zero %b expected %b", op, zero, (exp_r == 32'h0));
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle state after reset: add of zeros, R9 and R11
        apply(0, 32'h0, 32'h0, 16'h0, 5'd0);

        // R5 and R4: the named compare example
        apply(5, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0);
        apply(6, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0);
        // R1: negative immediate widened with ones
        apply(13, 32'h0000_0010, 32'h0, 16'hFFFF, 5'd0);
        // R2: and-immediate leaves upper half clear
        apply(16, 32'hFFFF_FFFF, 32'h0, 16'h8F0F, 5'd0);
        // R3: upper immediate ignores both operands
        apply(18, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h1234, 5'd7);

        // corner grid over every code, R1 to R12
        for (int op = 0; op < 24; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(op, corner(i), corner(j), corner(j)[15:0] ^ corner(i)[31:16], 5'((i * 5 + j * 3) % 32));

        // full count sweep per shift kind, R6 R7 R8
        for (int op = 7; op <= 12; op++)
            for (int s = 0; s < 32; s++) begin
                apply(op, {27'h5A5A5A5, 5'(s)}, 32'h8421_F00F, 16'h0, 5'(31 - s));
                apply(op, {27'h1234567, 5'(s)}, 32'h7BDE_0FF1, 16'h0, 5'(s ^ 5'h15));
            end

        // pseudo-random run over all 32 codes
        for (int k = 0; k < 4000; k++) begin
            step_lfsr(); ra = lfsr;
            step_lfsr(); rb = lfsr;
            step_lfsr();
            apply(int'(lfsr[4:0]), ra, rb, lfsr[31:16], lfsr[12:8]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule